// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block performs the state update a 64-bit processor core needs when it takes an exception. An exception request carries an enumerated cause. With it come the current program counter, a flag that marks an instruction in a branch delay slot, the current exception-level and boot-vector status bits, the faulting address, and a base offset. On the clock edge where the request is high, the block writes these values:

- the saved exception PC and the branch-delay flag;
- the 5-bit cause code;
- the exception-level bit;
- the bad-address register and the translation context fields.

On the same edge it registers the redirect target and raises a one-cycle redirect pulse.

The redirect target is a vector base plus a vector offset, minus the supplied base offset. The vector base depends on the boot-vector bit. The vector offset depends on the cause and on whether the core is already at exception level. A nested exception keeps the originally saved PC and delay flag and always goes to the common vector. The surrounding core owns the status register. It feeds the current exception-level bit in and uses `exlOut` as the value to write back.

Top module: `exc_entry_unit`

## Requirements
- R1: The cause index `excCause` maps to the cause code `causeCode` as follows:

  | Index | Cause | Code |
  |---|---|---|
  | 0 | interrupt | 0x00 |
  | 1 | TLB modify | 0x01 |
  | 2 | TLB load | 0x02 |
  | 3 | TLB store | 0x03 |
  | 4 | address error load | 0x04 |
  | 5 | address error store | 0x05 |
  | 6 | syscall | 0x08 |
  | 7 | breakpoint | 0x09 |
  | 8 | reserved instruction | 0x0A |
  | 9 | coprocessor unusable | 0x0B |
  | 10 | overflow | 0x0C |
  | 11 | trap | 0x0D |
  | 12 | coprocessor-2 exception | 0x12 |
  | 13 | coprocessor-2 trap | 0x12 |
  | 14 | refill load | 0x02 |
  | 15 | refill store | 0x03 |
  | 16 | invalid load | 0x02 |
  | 17 | invalid store | 0x03 |
  | 18 | machine check | 0x18 |

- R2: When `statusExl` is 0 and `inDelaySlot` is 1, the entry writes `epcOut` = `curPc` − 4 and `causeBd` = 1. When `statusExl` is 0 and `inDelaySlot` is 0, it writes `epcOut` = `curPc` and `causeBd` = 0.
- R3: When `statusExl` is 1, the entry leaves `epcOut` and `causeBd` unchanged.
- R4: The vector offset is chosen in this order:
  1. 0x180 if `statusExl` is 1;
  2. otherwise 0x080 for refill load or refill store (indices 14 and 15);
  3. otherwise 0x280 for coprocessor-2 trap (index 13);
  4. otherwise 0x180.
- R5: The redirect target `nextPc` is the vector base plus the sign-extended offset minus `baseOffset`. The vector base is 0xFFFFFFFFBFC00200 when `statusBev` is 1 and 0xFFFFFFFF80000000 when `statusBev` is 0.
- R6: Every entry sets `exlOut` to 1 and writes the cause code.
- R7: For TLB-class causes (indices 1, 2, 3, 14, 15, 16, 17), the entry writes the following fields from the faulting address `faultAddr`:

  | Port | Address bits |
  |---|---|
  | `badVaddr` | 63:0 (the full address) |
  | `ctxBadVpn2` | 31:13 |
  | `xctxBadVpn2` | 39:13 |
  | `hiVpn2` | 39:13 |
  | `xctxRegion` | 63:62 |
  | `hiRegion` | 63:62 |

- R8: For address-error causes (indices 4 and 5), the entry writes `badVaddr` only and leaves all context fields unchanged. Every other cause leaves `badVaddr` and the context fields unchanged.
- R9: All register updates happen on the clock edge where `excReq` is high. `redirect` is high for exactly the cycle after each such edge. After reset, every output is 0.
- R10: Cause indices 19 to 31 behave as machine check: code 0x18, common vector, and no address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excReq | input | 1 | Exception request, one cycle per exception |
| excCause | input | 5 | Cause index (encoding in R1) |
| curPc | input | 64 | PC of the faulting instruction |
| inDelaySlot | input | 1 | Faulting instruction is in a branch delay slot |
| statusExl | input | 1 | Current exception-level bit |
| statusBev | input | 1 | Current boot-vector bit |
| faultAddr | input | 64 | Faulting virtual address |
| baseOffset | input | 64 | Offset subtracted from the vector target |
| epcOut | output | 64 | Saved exception PC |
| causeBd | output | 1 | Branch-delay flag (cause bit 31) |
| causeCode | output | 5 | Cause code (cause bits 6:2) |
| exlOut | output | 1 | Exception-level value to write back |
| badVaddr | output | 64 | Bad virtual address register |
| ctxBadVpn2 | output | 19 | Context page-number field |
| xctxBadVpn2 | output | 27 | Extended-context page-number field |
| xctxRegion | output | 2 | Extended-context region field |
| hiVpn2 | output | 27 | Entry-high page-number field |
| hiRegion | output | 2 | Entry-high region field |
| nextPc | output | 64 | Registered redirect target |
| redirect | output | 1 | One-cycle redirect pulse |

## Verification
The assertions check the following on every cycle:

- the redirect pulse follows each request;
- `exlOut` is set after every entry;
- the saved PC and delay flag stay frozen during a nested entry;
- the delay-slot PC adjustment is applied;
- a nested entry with zero offset lands on the common vector;
- non-address causes leave the bad-address register alone.

Only the directed scenarios can show the following:

- the full cause-code table, including the fallback for indices above 18;
- the choice among the three vector offsets under both boot-vector settings;
- the base-offset subtraction;
- the exact slicing of address bits into the context fields;
- that an address error leaves context fields written by an earlier TLB exception unchanged.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XlenW    = 64;
  localparam int CodeW    = 5;
  localparam int CauseW   = 5;
  localparam int VpnLo    = 13;
  localparam int Vpn32Hi  = 31;
  localparam int VpnXHi   = 39;
  localparam int RegionHi = XlenW - 1;
  localparam int RegionLo = XlenW - 2;
  localparam int CtxW     = Vpn32Hi - VpnLo + 1;
  localparam int XCtxW    = VpnXHi - VpnLo + 1;
  localparam int RegionW  = RegionHi - RegionLo + 1;
  localparam int OffW     = 12;

  localparam logic [XlenW-1:0] BaseBoot   = 64'hFFFF_FFFF_BFC0_0200;
  localparam logic [XlenW-1:0] BaseNormal = 64'hFFFF_FFFF_8000_0000;
  localparam logic [OffW-1:0]  OffCommon  = 12'h180;
  localparam logic [OffW-1:0]  OffRefill  = 12'h080;
  localparam logic [OffW-1:0]  OffTrap    = 12'h280;

  typedef enum logic [CauseW-1:0] {
    CauseIrq        = 5'd0,
    CauseTlbMod     = 5'd1,
    CauseTlbLoad    = 5'd2,
    CauseTlbStore   = 5'd3,
    CauseAddrLoad   = 5'd4,
    CauseAddrStore  = 5'd5,
    CauseSyscall    = 5'd6,
    CauseBreak      = 5'd7,
    CauseResvInstr  = 5'd8,
    CauseCopUnusable = 5'd9,
    CauseOverflow   = 5'd10,
    CauseTrap       = 5'd11,
    CauseCop2Exc    = 5'd12,
    CauseCop2Trap   = 5'd13,
    CauseRefillLoad = 5'd14,
    CauseRefillStore = 5'd15,
    CauseInvLoad    = 5'd16,
    CauseInvStore   = 5'd17,
    CauseMachCheck  = 5'd18
  } cause_e;

  typedef enum logic [1:0] {
    VecCommon = 2'd0,
    VecRefill = 2'd1,
    VecTrap   = 2'd2
  } vec_e;

  typedef struct packed {
    logic             capture;
    logic             saveEpc;
    logic             loadBad;
    logic             loadCtx;
    logic [CodeW-1:0] code;
    vec_e             vecSel;
  } strobe_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              excReq,
  input  logic [CauseW-1:0] excCause,
  input  logic              statusExl,
  output strobe_t           stb
);
  logic [CodeW-1:0] codeSel;
  logic             tlbClass;
  logic             addrClass;
  logic             refillClass;
  logic             trapClass;

  always_comb begin
    codeSel     = 5'h18;
    tlbClass    = 1'b0;
    addrClass   = 1'b0;
    refillClass = 1'b0;
    trapClass   = 1'b0;
    case (excCause)
      CauseIrq:         codeSel = 5'h00;
      CauseTlbMod:      begin codeSel = 5'h01; tlbClass = 1'b1; end
      CauseTlbLoad:     begin codeSel = 5'h02; tlbClass = 1'b1; end
      CauseTlbStore:    begin codeSel = 5'h03; tlbClass = 1'b1; end
      CauseAddrLoad:    begin codeSel = 5'h04; addrClass = 1'b1; end
      CauseAddrStore:   begin codeSel = 5'h05; addrClass = 1'b1; end
      CauseSyscall:     codeSel = 5'h08;
      CauseBreak:       codeSel = 5'h09;
      CauseResvInstr:   codeSel = 5'h0A;
      CauseCopUnusable: codeSel = 5'h0B;
      CauseOverflow:    codeSel = 5'h0C;
      CauseTrap:        codeSel = 5'h0D;
      CauseCop2Exc:     codeSel = 5'h12;
      CauseCop2Trap:    begin codeSel = 5'h12; trapClass = 1'b1; end
      CauseRefillLoad:  begin codeSel = 5'h02; tlbClass = 1'b1; refillClass = 1'b1; end
      CauseRefillStore: begin codeSel = 5'h03; tlbClass = 1'b1; refillClass = 1'b1; end
      CauseInvLoad:     begin codeSel = 5'h02; tlbClass = 1'b1; end
      CauseInvStore:    begin codeSel = 5'h03; tlbClass = 1'b1; end
      default:          codeSel = 5'h18;
    endcase
  end

  always_comb begin
    stb.capture = excReq;
    stb.saveEpc = excReq && !statusExl;
    stb.loadBad = excReq && (tlbClass || addrClass);
    stb.loadCtx = excReq && tlbClass;
    stb.code    = codeSel;
    if (statusExl)        stb.vecSel = VecCommon;
    else if (refillClass) stb.vecSel = VecRefill;
    else if (trapClass)   stb.vecSel = VecTrap;
    else                  stb.vecSel = VecCommon;
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [XlenW-1:0]   curPc,
  input  logic               inDelaySlot,
  input  logic               statusBev,
  input  logic [XlenW-1:0]   faultAddr,
  input  logic [XlenW-1:0]   baseOffset,
  output logic [XlenW-1:0]   epcOut,
  output logic               causeBd,
  output logic [CodeW-1:0]   causeCode,
  output logic               exlOut,
  output logic [XlenW-1:0]   badVaddr,
  output logic [CtxW-1:0]    ctxBadVpn2,
  output logic [XCtxW-1:0]   xctxBadVpn2,
  output logic [RegionW-1:0] xctxRegion,
  output logic [XCtxW-1:0]   hiVpn2,
  output logic [RegionW-1:0] hiRegion,
  output logic [XlenW-1:0]   nextPc,
  output logic               redirect
);
  logic [OffW-1:0]  vecOff;
  logic [XlenW-1:0] vecBase;
  logic [XlenW-1:0] target;

  always_comb begin
    case (stb.vecSel)
      VecRefill: vecOff = OffRefill;
      VecTrap:   vecOff = OffTrap;
      default:   vecOff = OffCommon;
    endcase
    vecBase = statusBev ? BaseBoot : BaseNormal;
    target  = vecBase + {{(XlenW-OffW){vecOff[OffW-1]}}, vecOff} - baseOffset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcOut      <= '0;
      causeBd     <= 1'b0;
      causeCode   <= '0;
      exlOut      <= 1'b0;
      badVaddr    <= '0;
      ctxBadVpn2  <= '0;
      xctxBadVpn2 <= '0;
      xctxRegion  <= '0;
      hiVpn2      <= '0;
      hiRegion    <= '0;
      nextPc      <= '0;
      redirect    <= 1'b0;
    end else begin
      redirect <= stb.capture;
      if (stb.capture) begin
        causeCode <= stb.code;
        exlOut    <= 1'b1;
        nextPc    <= target;
      end
      if (stb.saveEpc) begin
        epcOut  <= inDelaySlot ? curPc - XlenW'(4) : curPc;
        causeBd <= inDelaySlot;
      end
      if (stb.loadBad) badVaddr <= faultAddr;
      if (stb.loadCtx) begin
        ctxBadVpn2  <= faultAddr[Vpn32Hi:VpnLo];
        xctxBadVpn2 <= faultAddr[VpnXHi:VpnLo];
        hiVpn2      <= faultAddr[VpnXHi:VpnLo];
        xctxRegion  <= faultAddr[RegionHi:RegionLo];
        hiRegion    <= faultAddr[RegionHi:RegionLo];
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic [CauseW-1:0]  excCause,
  input  logic [XlenW-1:0]   curPc,
  input  logic               inDelaySlot,
  input  logic               statusExl,
  input  logic               statusBev,
  input  logic [XlenW-1:0]   faultAddr,
  input  logic [XlenW-1:0]   baseOffset,
  output logic [XlenW-1:0]   epcOut,
  output logic               causeBd,
  output logic [CodeW-1:0]   causeCode,
  output logic               exlOut,
  output logic [XlenW-1:0]   badVaddr,
  output logic [CtxW-1:0]    ctxBadVpn2,
  output logic [XCtxW-1:0]   xctxBadVpn2,
  output logic [RegionW-1:0] xctxRegion,
  output logic [XCtxW-1:0]   hiVpn2,
  output logic [RegionW-1:0] hiRegion,
  output logic [XlenW-1:0]   nextPc,
  output logic               redirect
);
  strobe_t stb;

  exc_entry_ctrl u_ctrl (
    .excReq    (excReq),
    .excCause  (excCause),
    .statusExl (statusExl),
    .stb       (stb)
  );

  exc_entry_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .curPc       (curPc),
    .inDelaySlot (inDelaySlot),
    .statusBev   (statusBev),
    .faultAddr   (faultAddr),
    .baseOffset  (baseOffset),
    .epcOut      (epcOut),
    .causeBd     (causeBd),
    .causeCode   (causeCode),
    .exlOut      (exlOut),
    .badVaddr    (badVaddr),
    .ctxBadVpn2  (ctxBadVpn2),
    .xctxBadVpn2 (xctxBadVpn2),
    .xctxRegion  (xctxRegion),
    .hiVpn2      (hiVpn2),
    .hiRegion    (hiRegion),
    .nextPc      (nextPc),
    .redirect    (redirect)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               excReq,
  input logic [CauseW-1:0]  excCause,
  input logic [XlenW-1:0]   curPc,
  input logic               inDelaySlot,
  input logic               statusExl,
  input logic               statusBev,
  input logic [XlenW-1:0]   baseOffset,
  input logic [XlenW-1:0]   epcOut,
  input logic               causeBd,
  input logic               exlOut,
  input logic [XlenW-1:0]   badVaddr,
  input logic [XlenW-1:0]   nextPc,
  input logic               redirect
);
  a_r9_redirect_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> redirect);

  a_r9_redirect_only_after_req: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> !redirect);

  a_r6_exl_set: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> exlOut);

  a_r3_nested_keeps_epc: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && statusExl) |=> ($stable(epcOut) && $stable(causeBd)));

  a_r2_delay_slot_epc: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !statusExl && inDelaySlot) |=> (causeBd && epcOut == $past(curPc) - 64'd4));

  a_r4_nested_common_vector: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && statusExl && !statusBev && baseOffset == '0) |=> (nextPc == 64'hFFFF_FFFF_8000_0180));

  a_r8_no_addr_capture: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && (excCause == 5'd0 || (excCause >= 5'd6 && excCause <= 5'd13))) |=> $stable(badVaddr));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (.*);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCause = '0;
  logic [63:0] curPc = '0;
  logic        inDelaySlot = 1'b0;
  logic        statusExl = 1'b0;
  logic        statusBev = 1'b0;
  logic [63:0] faultAddr = '0;
  logic [63:0] baseOffset = '0;
  logic [63:0] epcOut, badVaddr, nextPc;
  logic        causeBd, exlOut, redirect;
  logic [4:0]  causeCode;
  logic [18:0] ctxBadVpn2;
  logic [26:0] xctxBadVpn2, hiVpn2;
  logic [1:0]  xctxRegion, hiRegion;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  exc_entry_unit dut (.*);

  always #4 clk = ~clk; // 8-unit period, 125 MHz

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expCode(input int idx);
    case (idx)
      0: return 5'h00;  1: return 5'h01;  2: return 5'h02;  3: return 5'h03;
      4: return 5'h04;  5: return 5'h05;  6: return 5'h08;  7: return 5'h09;
      8: return 5'h0A;  9: return 5'h0B;  10: return 5'h0C; 11: return 5'h0D;
      12: return 5'h12; 13: return 5'h12; 14: return 5'h02; 15: return 5'h03;
      16: return 5'h02; 17: return 5'h03; default: return 5'h18;
    endcase
  endfunction

  task automatic raise(input int cause, input logic [63:0] pc, input logic ds,
                       input logic exl, input logic bev, input logic [63:0] addr,
                       input logic [63:0] off);
    @(negedge clk);
    excCause = 5'(cause); curPc = pc; inDelaySlot = ds; statusExl = exl;
    statusBev = bev; faultAddr = addr; baseOffset = off; excReq = 1'b1;
    @(posedge clk);
    #1 excReq = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset epc", epcOut, 0);
    chk("R9 reset redirect", 64'(redirect), 0);
    chk("R9 reset exl", 64'(exlOut), 0);
    chk("R9 reset nextPc", nextPc, 0);
    chk("R9 reset badVaddr", badVaddr, 0);
  endtask

  task automatic t_delay_slot;
    raise(6, 64'h1000, 1'b1, 1'b0, 1'b1, 64'hDEAD, 0);
    chk("R2 epc ds", epcOut, 64'hFFC);
    chk("R2 bd ds", 64'(causeBd), 1);
    chk("R1 syscall code", 64'(causeCode), 8);
    chk("R5 boot common", nextPc, 64'hFFFF_FFFF_BFC0_0380);
    chk("R6 exl", 64'(exlOut), 1);
    chk("R9 redirect", 64'(redirect), 1);
    chk("R8 syscall no bad", badVaddr, 0);
    @(posedge clk); #1;
    chk("R9 redirect drop", 64'(redirect), 0);
  endtask

  task automatic t_no_slot;
    raise(7, 64'h2000, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R2 epc", epcOut, 64'h2000);
    chk("R2 bd", 64'(causeBd), 0);
    chk("R1 break code", 64'(causeCode), 9);
    chk("R5 normal common", nextPc, 64'hFFFF_FFFF_8000_0180);
  endtask

  task automatic t_nested;
    raise(2, 64'h3000, 1'b0, 1'b0, 1'b0, 64'h1234_5000, 0);
    chk("R2 first epc", epcOut, 64'h3000);
    raise(14, 64'h4000, 1'b1, 1'b1, 1'b0, 64'h5678_A000, 0);
    chk("R3 nested epc kept", epcOut, 64'h3000);
    chk("R3 nested bd kept", 64'(causeBd), 0);
    chk("R4 nested common vector", nextPc, 64'hFFFF_FFFF_8000_0180);
    chk("R1 refill load code", 64'(causeCode), 2);
    chk("R7 nested bad addr", badVaddr, 64'h5678_A000);
    chk("R9 nested redirect", 64'(redirect), 1);
  endtask

  task automatic t_refill;
    logic [63:0] a = 64'hC000_00AB_CDEF_2000;
    raise(15, 64'h5000, 1'b0, 1'b0, 1'b0, a, 0);
    chk("R4 refill vector", nextPc, 64'hFFFF_FFFF_8000_0080);
    chk("R1 refill store code", 64'(causeCode), 3);
    chk("R7 bad", badVaddr, a);
    chk("R7 ctx", 64'(ctxBadVpn2), 64'(a[31:13]));
    chk("R7 xctx", 64'(xctxBadVpn2), 64'(a[39:13]));
    chk("R7 hi vpn", 64'(hiVpn2), 64'(a[39:13]));
    chk("R7 xr", 64'(xctxRegion), 3);
    chk("R7 hi region", 64'(hiRegion), 3);
  endtask

  task automatic t_addr_err;
    logic [63:0] a = 64'h4000_0012_3456_6000;
    raise(1, 64'h6000, 1'b0, 1'b0, 1'b1, a, 0);
    raise(5, 64'h6004, 1'b0, 1'b0, 1'b1, 64'h0000_0000_7777_7771, 0);
    chk("R8 addr err bad", badVaddr, 64'h7777_7771);
    chk("R1 addr store code", 64'(causeCode), 5);
    chk("R8 ctx kept", 64'(ctxBadVpn2), 64'(a[31:13]));
    chk("R8 xctx kept", 64'(xctxBadVpn2), 64'(a[39:13]));
    chk("R8 region kept", 64'(hiRegion), 1);
    raise(10, 64'h6008, 1'b0, 1'b0, 1'b1, 64'hFFFF, 0);
    chk("R8 overflow bad kept", badVaddr, 64'h7777_7771);
  endtask

  task automatic t_trap_offset;
    raise(13, 64'h7000, 1'b0, 1'b0, 1'b1, 0, 64'h100);
    chk("R4 trap vector offset", nextPc, 64'hFFFF_FFFF_BFC0_0380);
    chk("R1 cop2 trap code", 64'(causeCode), 5'h12);
    raise(12, 64'h7000, 1'b0, 1'b0, 1'b0, 0, 64'h8000_0000);
    chk("R5 cop2 exc offset", nextPc, 64'hFFFF_FFFF_0000_0180);
    chk("R1 cop2 exc code", 64'(causeCode), 5'h12);
  endtask

  task automatic t_codes;
    for (int i = 0; i < 22; i++) begin
      int idx = (i < 19) ? i : 6 + i;
      logic [63:0] vec = (idx == 14 || idx == 15) ? 64'hFFFF_FFFF_8000_0080 :
                         (idx == 13) ? 64'hFFFF_FFFF_8000_0280 : 64'hFFFF_FFFF_8000_0180;
      raise(idx, 64'h8000, 1'b0, 1'b0, 1'b0, 0, 0);
      if (idx > 18) begin
        chk("R10 fallback code", 64'(causeCode), 5'h18);
        chk("R10 fallback vector", nextPc, vec);
      end else begin
        chk("R1 code table", 64'(causeCode), 64'(expCode(idx)));
        chk("R4 vector table", nextPc, vec);
      end
    end
  endtask

  initial begin
    #3 t_reset;
    #20 rstN = 1'b1;
    t_delay_slot;
    t_no_slot;
    t_nested;
    t_refill;
    t_addr_err;
    t_trap_offset;
    t_codes;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule